// File: doc/BRIEF.md
# Two-Stage Fault Latch Controller

This block supervises an active-low, already debounced fault input for a power-factor stage controller. When the fault input falls during normal operation, the block immediately forces both the power-switch gate drive and the bias-rail control into their off state. It then waits a fixed resample interval and reads the fault input a second time. If the fault has gone away by then, it hands control back to the startup sequencer with a single-cycle restart request. If the fault is still present, it enters a latched shutdown.

A latched shutdown is released by the line voltage alone. A comparator flag must report the line below its clear level for an unbroken span of time. Any gap restarts that span. After the release, the block waits a long hold-off with the outputs still forced off. It then requests a restart, but only once a second flag reports the line at or above its start level. A fault during the hold-off starts the resample sequence again. All intervals are counted in strobes of an external time base, so one parameter set can serve any clock rate. A synchronous reset acts as power-on reset and also clears the latch.

Top module: `fault_latch_ctrl`

## Requirements
- R1: After reset, gate_kill, bias_kill, latched and restart_req are all 0.
- R2: While running (gate_kill = 0), a 0 on fault_n drives gate_kill and bias_kill to 1 at the next clock edge. Both stay 1 until a restart request is issued.
- R3: The fault input is sampled again on the clock after RESAMPLE_TICKS tick strobes have elapsed since the fault was taken. If fault_n is 1 at that point, restart_req pulses high for exactly one cycle and both kill outputs return to 0 in that same cycle.
- R4: If fault_n is 0 at the resample point, latched becomes 1 and both kill outputs stay 1.
- R5: While latched, changes on fault_n have no effect. latched and the kill outputs hold their value until the line-clear condition of R6 is met.
- R6: The latch clears only after line_low has been 1 on CLEAR_TICKS consecutive tick strobes. A 0 on line_low before that resets the span to zero.
- R7: Once the latch clears, latched is 0 but the kill outputs stay 1 for at least HOLDOFF_TICKS tick strobes. The restart request is then issued only when line_ok is 1, and the block waits as long as line_ok is 0.
- R8: A 0 on fault_n during the hold-off re-enters the resample sequence of R3/R4. A cleared fault then restarts without waiting out the rest of the hold-off.
- R9: Reset clears a latched shutdown and returns the block to the running state.
- R10: All intervals advance only on clock edges where tick is 1. With tick held at 0, no resample decision, latch release or hold-off expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, used as power-on reset |
| tick | input | 1 | Time-base strobe, one cycle per time unit |
| fault_n | input | 1 | Debounced fault input, 0 = fault present |
| line_low | input | 1 | Line voltage is below the latch-clear level |
| line_ok | input | 1 | Line voltage is at or above the start level |
| gate_kill | output | 1 | Forces the power-switch gate drive off |
| bias_kill | output | 1 | Forces the bias-rail control off |
| restart_req | output | 1 | One-cycle request to the startup sequencer |
| latched | output | 1 | Latched shutdown is in effect |

## Verification
Internal state shows at the ports in only a few ways. A wrong state or a miscounted interval appears as a kill output released too early or held too long, a restart pulse missing or duplicated, or latched rising or falling at the wrong moment. Every state change reaches the outputs on the clock after it happens, so a fault taken late or a resample decision taken with the wrong fault_n value shows within one resample interval. A span counter that forgets to reset on a line_low gap shows as a latch that clears too soon. A hold-off that is skipped or ignores a new fault shows as an unexpected or missing restart request.

// File: rtl/fl_pkg.sv
package fl_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PROBE = 2'd1,
        ST_LOCK  = 2'd2,
        ST_HOLD  = 2'd3
    } fl_state_e;

    typedef struct packed {
        logic gate_kill;
        logic bias_kill;
        logic latched;
    } fl_out_s;

    function automatic fl_out_s outs_of(fl_state_e s);
        fl_out_s o;
        o.gate_kill = (s != ST_RUN);
        o.bias_kill = (s != ST_RUN);
        o.latched   = (s == ST_LOCK);
        return o;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fl_span_cnt.sv
module fl_span_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (adv && !done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fl_seq.sv
module fl_seq
    import fl_pkg::*;
#(
    parameter int W               = 8,
    parameter int RESAMPLE_TICKS  = 100,
    parameter int CLEAR_TICKS     = 120000,
    parameter int HOLDOFF_TICKS   = 10000000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         fault_n,
    input  logic         line_low,
    input  logic         line_ok,
    input  logic         span_done,
    output logic         span_clr,
    output logic         span_adv,
    output logic [W-1:0] span_limit,
    output fl_out_s      outs,
    output logic         restart_req
);
    fl_state_e state, state_nxt;
    logic      restart_nxt;

    always_comb begin
        state_nxt   = state;
        span_clr    = 1'b0;
        span_adv    = tick;
        span_limit  = W'(RESAMPLE_TICKS);
        restart_nxt = 1'b0;
        unique case (state)
            ST_RUN: begin
                span_clr = 1'b1;
                if (!fault_n) state_nxt = ST_PROBE;
            end
            ST_PROBE: begin
                if (span_done) begin
                    span_clr = 1'b1;
                    if (fault_n) begin
                        state_nxt   = ST_RUN;
                        restart_nxt = 1'b1;
                    end else begin
                        state_nxt = ST_LOCK;
                    end
                end
            end
            ST_LOCK: begin
                span_limit = W'(CLEAR_TICKS);
                span_adv   = tick && line_low;
                if (!line_low) begin
                    span_clr = 1'b1;
                end else if (span_done) begin
                    span_clr  = 1'b1;
                    state_nxt = ST_HOLD;
                end
            end
            ST_HOLD: begin
                span_limit = W'(HOLDOFF_TICKS);
                if (!fault_n) begin
                    span_clr  = 1'b1;
                    state_nxt = ST_PROBE;
                end else if (span_done && line_ok) begin
                    span_clr    = 1'b1;
                    state_nxt   = ST_RUN;
                    restart_nxt = 1'b1;
                end
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_RUN;
            restart_req <= 1'b0;
        end else begin
            state       <= state_nxt;
            restart_req <= restart_nxt;
        end
    end

    assign outs = outs_of(state);
endmodule

// File: rtl/fault_latch_ctrl.sv
module fault_latch_ctrl
    import fl_pkg::*;
#(
    parameter int RESAMPLE_TICKS = 100,
    parameter int CLEAR_TICKS    = 120000,
    parameter int HOLDOFF_TICKS  = 10000000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fault_n,
    input  logic line_low,
    input  logic line_ok,
    output logic gate_kill,
    output logic bias_kill,
    output logic restart_req,
    output logic latched
);
    localparam int unsigned LIM_MAX = max3(RESAMPLE_TICKS, CLEAR_TICKS, HOLDOFF_TICKS);
    localparam int W = $clog2(LIM_MAX + 1);

    logic         span_clr, span_adv, span_done;
    logic [W-1:0] span_limit;
    fl_out_s      outs;

    fl_span_cnt #(.W(W)) u_span (
        .clk   (clk),
        .rst   (rst),
        .clr   (span_clr),
        .adv   (span_adv),
        .limit (span_limit),
        .done  (span_done)
    );

    fl_seq #(
        .W              (W),
        .RESAMPLE_TICKS (RESAMPLE_TICKS),
        .CLEAR_TICKS    (CLEAR_TICKS),
        .HOLDOFF_TICKS  (HOLDOFF_TICKS)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .fault_n     (fault_n),
        .line_low    (line_low),
        .line_ok     (line_ok),
        .span_done   (span_done),
        .span_clr    (span_clr),
        .span_adv    (span_adv),
        .span_limit  (span_limit),
        .outs        (outs),
        .restart_req (restart_req)
    );

    assign gate_kill = outs.gate_kill;
    assign bias_kill = outs.bias_kill;
    assign latched   = outs.latched;
endmodule

// File: rtl/fault_latch_ctrl_chk.sv
module fault_latch_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic fault_n,
    input logic line_low,
    input logic gate_kill,
    input logic bias_kill,
    input logic restart_req,
    input logic latched
);
    // R2: a fault taken while running kills the outputs on the next edge
    a_r2_kill_on_fault: assert property (@(posedge clk) disable iff (rst)
        (!gate_kill && !fault_n) |=> (gate_kill && bias_kill));

    // R3: restart request is a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        restart_req |=> !restart_req);

    // R3: kills released together with the restart request
    a_r3_release: assert property (@(posedge clk) disable iff (rst)
        restart_req |-> (!gate_kill && !bias_kill));

    // R4: latching requires the fault still present at the decision edge
    a_r4_latch_entry: assert property (@(posedge clk) disable iff (rst)
        ($rose(latched) && !$past(rst)) |-> $past(!fault_n));

    // R4: latched shutdown keeps the outputs off
    a_r4_latched_kills: assert property (@(posedge clk) disable iff (rst)
        latched |-> (gate_kill && bias_kill));

    // R5: without line_low the latch holds
    a_r5_hold_latch: assert property (@(posedge clk) disable iff (rst)
        (latched && !line_low) |=> latched);

    // R6: leaving the latch needs line_low at the release edge
    a_r6_clear_line: assert property (@(posedge clk) disable iff (rst)
        ($fell(latched) && !$past(rst)) |-> $past(line_low));

    // R7: clearing the latch does not release the outputs at once
    a_r7_hold_kill: assert property (@(posedge clk) disable iff (rst)
        ($fell(latched) && !$past(rst)) |-> gate_kill);
endmodule

bind fault_latch_ctrl fault_latch_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fault_n     (fault_n),
    .line_low    (line_low),
    .gate_kill   (gate_kill),
    .bias_kill   (bias_kill),
    .restart_req (restart_req),
    .latched     (latched)
);

// File: tb/fault_latch_ctrl_test.sv
`timescale 1ns/1ps
module fault_latch_ctrl_test;
    localparam int RS = 8;
    localparam int CL = 20;
    localparam int HO = 30;

    logic clk = 1'b0;
    logic rst, tick, fault_n, line_low, line_ok;
    logic gate_kill, bias_kill, restart_req, latched;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    string exp_q[$];

    always #4 clk = ~clk;

    fault_latch_ctrl #(
        .RESAMPLE_TICKS (RS),
        .CLEAR_TICKS    (CL),
        .HOLDOFF_TICKS  (HO)
    ) uut (
        .clk (clk), .rst (rst), .tick (tick), .fault_n (fault_n),
        .line_low (line_low), .line_ok (line_ok),
        .gate_kill (gate_kill), .bias_kill (bias_kill),
        .restart_req (restart_req), .latched (latched)
    );

    task automatic check(string tag, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: each restart pulse consumes one expected item
    always @(negedge clk) begin
        if (!rst && restart_req === 1'b1) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R3/R7 unexpected restart: actual 1 expected 0");
            end else begin
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic long_fault();
        fault_n = 1'b0; cyc(RS + 7);
        fault_n = 1'b1; cyc(1);
    endtask

    task automatic clear_latch();
        line_low = 1'b1; cyc(CL + 5);
        line_low = 1'b0; cyc(1);
    endtask

    initial begin
        rst = 1'b1; tick = 1'b1; fault_n = 1'b1; line_low = 1'b0; line_ok = 1'b1;
        cyc(3);
        rst = 1'b0; cyc(1);
        check("R1 gate_kill", gate_kill, 1'b0);
        check("R1 bias_kill", bias_kill, 1'b0);
        check("R1 latched", latched, 1'b0);
        check("R1 restart_req", restart_req, 1'b0);

        // short fault -> restart
        fault_n = 1'b0; cyc(1);
        check("R2 gate_kill", gate_kill, 1'b1);
        check("R2 bias_kill", bias_kill, 1'b1);
        cyc(2);
        exp_q.push_back("R3 short fault");
        fault_n = 1'b1; cyc(RS + 6);
        check("R3 gate released", gate_kill, 1'b0);
        check("R3 not latched", latched, 1'b0);

        // long fault -> latch, fault changes ignored
        long_fault();
        check("R4 latched", latched, 1'b1);
        check("R4 gate_kill", gate_kill, 1'b1);
        fault_n = 1'b0; cyc(5); fault_n = 1'b1; cyc(5);
        check("R5 latch holds", latched, 1'b1);
        check("R5 gate holds", gate_kill, 1'b1);

        // interrupted line-low span does not clear
        line_low = 1'b1; cyc(CL - 2);
        line_low = 1'b0; cyc(2);
        line_low = 1'b1; cyc(CL - 2);
        check("R6 gap restarts span", latched, 1'b1);
        cyc(6);
        line_low = 1'b0; cyc(1);
        check("R6 latch cleared", latched, 1'b0);
        check("R7 gate held in hold-off", gate_kill, 1'b1);

        // hold-off waits for line_ok
        line_ok = 1'b0; cyc(HO + 15);
        check("R7 waits for line_ok", gate_kill, 1'b1);
        check("R7 bias waits", bias_kill, 1'b1);
        exp_q.push_back("R7 hold-off restart");
        line_ok = 1'b1; cyc(3);
        check("R7 released", gate_kill, 1'b0);

        // fault during hold-off -> resample path
        long_fault();
        clear_latch();
        fault_n = 1'b0; cyc(3);
        exp_q.push_back("R8 resample restart");
        fault_n = 1'b1; cyc(RS + 4);
        check("R8 early restart", gate_kill, 1'b0);
        check("R8 not latched", latched, 1'b0);

        // no ticks -> no progress
        tick = 1'b0;
        fault_n = 1'b0; cyc(RS * 4);
        fault_n = 1'b1; cyc(3);
        check("R10 still waiting", gate_kill, 1'b1);
        check("R10 no latch", latched, 1'b0);
        exp_q.push_back("R10 tick resumes");
        tick = 1'b1; cyc(RS + 4);
        check("R10 restart after ticks", gate_kill, 1'b0);

        // reset clears latch
        long_fault();
        check("R9 latched before reset", latched, 1'b1);
        rst = 1'b1; cyc(2);
        rst = 1'b0; cyc(1);
        check("R9 latch cleared", latched, 1'b0);
        check("R9 gate released", gate_kill, 1'b0);

        cyc(3);
        while (exp_q.size() > 0) begin
            compared++; mismatched++;
            $display("FAIL %s missing restart: actual 0 expected 1", exp_q.pop_front());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule